// File: doc/BRIEF.md
# Inverting Registered Bus Transceiver

The block sits between two 8-bit buses, called A and B. It carries data from either one to the other, and every path it drives inverts the bits. Each direction has its own storage register. A per-direction select picks what the driven bus receives: the live value of the opposite bus, or the value held in that direction's register. Real tri-state pins are replaced by separate signals: each side has an input vector, an output vector and a single output-enable line. The chip-level pad or bus logic merges these into the physical bus.

Both registers run on the system clock and load on a per-direction load strobe. A load happens whatever the enables and selects are set to. This lets the block hold a snapshot of either bus while it stays isolated. It can also copy one bus into both registers: one side drives the other live, and both registers are loaded in the same cycle. The B-side enable is active high and the A-side enable is active low. An asynchronous reset clears both registers and keeps both sides from driving.

Top module: `inv_bus_xcvr`

## Requirements
- R1: While rst_n is low, a_oe and b_oe are 0 with no clock edge needed, and both registers are held at zero. After release, a side that selects its stored path outputs 8'hFF.
- R2: The A-to-B register takes a_in at a rising clk edge when ld_ab is 1. With ld_ab at 0 it keeps its value whatever a_in does.
- R3: The B-to-A register takes b_in at a rising clk edge when ld_ba is 1. With ld_ba at 0 it keeps its value whatever b_in does.
- R4: Loads happen with both sides isolated and with any select setting. Enables and selects never block a load.
- R5: With sel_ab at 0, b_out is ~a_in (live path). With sel_ab at 1, b_out is the bitwise inverse of the A-to-B register.
- R6: With sel_ba at 0, a_out is ~b_in. With sel_ba at 1, a_out is the bitwise inverse of the B-to-A register.
- R7: Out of reset, b_oe follows oe_ab (active high) and a_oe follows the inverse of oe_ba_n (active low). oe_ab=0 with oe_ba_n=1 isolates both sides.
- R8: With oe_ab=1, oe_ba_n=0 and both selects at 1, both sides drive at once. B carries the inverse of the A-to-B register and A carries the inverse of the B-to-A register.
- R9: When both loads fire in the same cycle, each register takes the bus value present before that edge. So a bus driven live by the block can be stored in both registers in one cycle, and with both stored paths driving, a joint load swaps the inverted contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_ab | input | 1 | Load strobe for the A-to-B register |
| ld_ba | input | 1 | Load strobe for the B-to-A register |
| sel_ab | input | 1 | B-side source: 0 live A, 1 stored |
| sel_ba | input | 1 | A-side source: 0 live B, 1 stored |
| oe_ab | input | 1 | B-side drive enable, active high |
| oe_ba_n | input | 1 | A-side drive enable, active low |
| a_in | input | W | Resolved value seen on bus A |
| a_out | output | W | Value the block drives onto bus A |
| a_oe | output | 1 | Block drives bus A |
| b_in | input | W | Resolved value seen on bus B |
| b_out | output | W | Value the block drives onto bus B |
| b_oe | output | 1 | Block drives bus B |

## Verification
A register holding the wrong value stays hidden until its side selects the stored path. From then on it is seen at once and combinationally, as the inverse of the bad value on the driven bus. For that reason every stored-value check first isolates or reconfigures the bus, then reads through the stored path on the following cycle. A bad load or hold shows one clock after the strobe. The joint-load swap catches a register that samples post-edge data, because the swapped results differ from those of a sequential update.

// File: rtl/inv_bus_xcvr.sv
module inv_bus_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_ab,
  input  logic         ld_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         oe_ab,
  input  logic         oe_ba_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  logic [W-1:0] reg_ab, reg_ba;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     reg_ab <= '0;
    else if (ld_ab) reg_ab <= a_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     reg_ba <= '0;
    else if (ld_ba) reg_ba <= b_in;

  assign b_out = ~(sel_ab ? reg_ab : a_in);
  assign a_out = ~(sel_ba ? reg_ba : b_in);
  assign b_oe  = rst_n & oe_ab;
  assign a_oe  = rst_n & ~oe_ba_n;

endmodule

module inv_bus_xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ld_ab,
  input logic         ld_ba,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         a_oe,
  input logic         b_oe,
  input logic [W-1:0] reg_ab,
  input logic [W-1:0] reg_ba
);

  always_comb
    if (!rst_n) AST_RESET_QUIET: assert (!a_oe && !b_oe); // R1

  AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) ld_ab |=> reg_ab == $past(a_in)); // R2
  AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ld_ab |=> $stable(reg_ab)); // R2
  AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) ld_ba |=> reg_ba == $past(b_in)); // R3
  AST_BA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ld_ba |=> $stable(reg_ba)); // R3
  AST_B_STORED_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (sel_ab && $past(sel_ab) && !$past(ld_ab)) |-> $stable(b_out)); // R5
  AST_A_STORED_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (sel_ba && $past(sel_ba) && !$past(ld_ba)) |-> $stable(a_out)); // R6

endmodule

bind inv_bus_xcvr inv_bus_xcvr_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_ab(ld_ab), .ld_ba(ld_ba),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
  .a_out(a_out), .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe),
  .reg_ab(reg_ab), .reg_ba(reg_ba)
);

// File: tb/sim_inv_bus_xcvr.sv
`timescale 1ns/1ps
module sim_inv_bus_xcvr;
  logic clk = 0, rst_n = 0;
  logic ld_ab = 0, ld_ba = 0, sel_ab = 0, sel_ba = 0, oe_ab = 0, oe_ba_n = 1;
  logic [7:0] ext_a = 0, ext_b = 0;
  logic ext_a_en = 0, ext_b_en = 0;
  logic [7:0] a_bus, b_bus, a_out, b_out;
  logic a_oe, b_oe;
  logic [7:0] mab = 0, mba = 0, oab, oba;
  int checks = 0, fails = 0, clash = 0;

  always #10 clk = ~clk;

  assign #1 a_bus = (ext_a_en ? ext_a : 8'h00) | (a_oe ? a_out : 8'h00);
  assign #1 b_bus = (ext_b_en ? ext_b : 8'h00) | (b_oe ? b_out : 8'h00);

  inv_bus_xcvr u0 (
    .clk(clk), .rst_n(rst_n), .ld_ab(ld_ab), .ld_ba(ld_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
    .a_in(a_bus), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_bus), .b_out(b_out), .b_oe(b_oe)
  );

  always @(posedge clk)
    if (rst_n && ((ext_a_en && a_oe) || (ext_b_en && b_oe))) clash++;

  task automatic check(input string req, input [7:0] act, input [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #4;
  endtask

  task automatic pulse(input logic la, input logic lb);
    @(negedge clk); ld_ab = la; ld_ba = lb;
    @(negedge clk); ld_ab = 0; ld_ba = 0;
    #4;
  endtask

  task automatic t_reset();
    #3; check("R1 a_oe in reset", {7'b0, a_oe}, 8'h00);
    check("R1 b_oe in reset", {7'b0, b_oe}, 8'h00);
    oe_ab = 1; oe_ba_n = 0;
    #2; check("R1 oe forced low", {6'b0, a_oe, b_oe}, 8'h00);
    @(negedge clk); rst_n = 1; sel_ab = 1; sel_ba = 1;
    settle();
    check("R1 b stored zero", b_out, 8'hFF);
    check("R1 a stored zero", a_out, 8'hFF);
    oe_ab = 0; oe_ba_n = 1;
  endtask

  task automatic t_isolate();
    oe_ab = 0; oe_ba_n = 1; sel_ab = 0; sel_ba = 0;
    ext_a = 8'h5A; ext_b = 8'h33; ext_a_en = 1; ext_b_en = 1;
    settle();
    check("R7 isolation oe", {6'b0, a_oe, b_oe}, 8'h00);
    pulse(1, 1); mab = 8'h5A; mba = 8'h33;
    ext_b_en = 0; oe_ab = 1; sel_ab = 1;
    settle();
    check("R4 stored A while isolated", b_out, ~mab);
    check("R7 b_oe high", {7'b0, b_oe}, 8'h01);
    oe_ab = 0; ext_a_en = 0; oe_ba_n = 0; sel_ba = 1;
    settle();
    check("R4 stored B while isolated", a_out, ~mba);
    check("R7 a_oe on low enable", {7'b0, a_oe}, 8'h01);
    oe_ba_n = 1;
    settle();
  endtask

  task automatic t_a_to_b();
    ext_b_en = 0; ext_a_en = 1; ext_a = 8'h3C; oe_ab = 1; sel_ab = 0;
    settle();
    check("R5 live A to B", b_bus, 8'hC3);
    ext_a = 8'h0F;
    settle();
    check("R5 live A follows", b_out, 8'hF0);
    ext_a = 8'h81; sel_ab = 1;
    pulse(1, 0); mab = 8'h81;
    check("R2 loaded A stored", b_out, 8'h7E);
    ext_a = 8'hFF;
    settle(); settle();
    check("R2 hold without load", b_bus, 8'h7E);
    oe_ab = 0; ext_a_en = 0;
    settle();
  endtask

  task automatic t_b_to_a();
    ext_a_en = 0; ext_b_en = 1; ext_b = 8'h96; oe_ba_n = 0; sel_ba = 0;
    settle();
    check("R6 live B to A", a_bus, 8'h69);
    ext_b = 8'h42; sel_ba = 1;
    pulse(0, 1); mba = 8'h42;
    check("R3 loaded B stored", a_out, 8'hBD);
    ext_b = 8'h00;
    settle(); settle();
    check("R3 hold without load", a_bus, 8'hBD);
    oe_ba_n = 1; ext_b_en = 0;
    settle();
  endtask

  task automatic t_both_stored();
    ext_a_en = 0; ext_b_en = 0; sel_ab = 1; sel_ba = 1; oe_ab = 1; oe_ba_n = 0;
    settle();
    check("R8 both oe", {6'b0, a_oe, b_oe}, 8'h03);
    check("R8 B gets stored A", b_bus, ~mab);
    check("R8 A gets stored B", a_bus, ~mba);
    oab = mab; oba = mba;
    pulse(1, 1); mab = ~oba; mba = ~oab;
    check("R9 swap B side", b_out, ~mab);
    check("R9 swap A side", a_out, ~mba);
    oe_ab = 0; oe_ba_n = 1;
    settle();
  endtask

  task automatic t_copy_a();
    ext_b_en = 0; ext_a_en = 1; ext_a = 8'h24; oe_ab = 1; oe_ba_n = 1; sel_ab = 0;
    settle();
    pulse(1, 1); mab = 8'h24; mba = 8'hDB;
    sel_ab = 1;
    settle();
    check("R9 A copy in AB reg", b_out, 8'hDB);
    oe_ab = 0; ext_a_en = 0; oe_ba_n = 0; sel_ba = 1;
    settle();
    check("R9 A copy in BA reg", a_bus, 8'h24);
  endtask

  task automatic t_async_reset();
    oe_ab = 1; oe_ba_n = 0; sel_ab = 1; sel_ba = 1;
    settle();
    #3; rst_n = 0; #2;
    check("R1 async oe drop", {6'b0, a_oe, b_oe}, 8'h00);
    @(negedge clk); rst_n = 1;
    settle();
    check("R1 AB reg cleared", b_out, 8'hFF);
    check("R1 BA reg cleared", a_out, 8'hFF);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_isolate();
    t_a_to_b();
    t_b_to_a();
    t_both_stored();
    t_copy_a();
    t_async_reset();
    check("R7 no bus contention", clash[7:0], 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule